// File: doc/BRIEF.md
# Viterbi Add-Compare-Select Butterfly Engine

This block carries out the path-metric recursion of a 16-state (constraint length 5) convolutional-code Viterbi decoder. One trellis step is eight radix-2 butterflies, and the engine processes one butterfly per clock. Butterfly `j` takes the stored metrics of states `j` and `j+8` and one signed branch metric. It forms two candidates for each of the new states `2j` and `2j+1`, keeps the larger one, and records which side won as a single decision bit.

The path metrics sit in two banks that swap roles at the end of each step. Every butterfly therefore reads the metrics of the previous step while it writes the new ones, and no read can collide with a write. Each butterfly's pair of decision bits is shifted into a decision register from the right. After the eighth butterfly, the full 16-bit word appears together with a one-cycle done strobe, ready to be stored in one write. The metrics are renormalised by subtracting the metric of state 0, which keeps them bounded.

A step begins with a start strobe that arrives together with the first branch metric. The next seven branch metrics follow on consecutive cycles. The next step may begin in the cycle in which the done strobe is high.

Top module: `acs_butterfly_core`

## Requirements
- R1: After reset, every state metric reads 0, and `pm_vld` and `dec_done` are low.
- R2: A start in cycle c presents branch metric 0 in cycle c, and branch metrics 1 to 7 follow in cycles c+1 to c+7. Butterfly `j` reads states `j` and `j+8`. One cycle after its branch metric is presented, `pm_vld` is high, `pm_pair` equals `j`, and `pm_even` and `pm_odd` carry the new metrics of states `2j` and `2j+1`.
- R3: For old metrics a (state j) and b (state j+8) and branch metric m, the new even metric is max(a+m, b-m) and the new odd metric is max(a-m, b+m). All arithmetic is 16-bit two's complement, and the comparison is signed.
- R4: A decision bit is 1 only when the candidate derived from state `j+8` is strictly larger. On a tie it is 0, and the candidate from state `j` survives.
- R5: `dec_done` is high for exactly one cycle, in the cycle after branch metric 7 was presented. In that cycle, `dec_word` holds the decision bits of butterfly `j`: the even-state bit at position 15-2j and the odd-state bit at position 14-2j.
- R6: After a step completes, the value read for state s equals the new raw metric of s minus the new raw metric of state 0, so state 0 reads 0.
- R7: A start asserted while a step is in progress has no effect. The butterfly sequence and the done timing of that step are unchanged.
- R8: A start in the cycle in which `dec_done` is high begins the next step at once, and that step uses the metrics the finished step produced.
- R9: `rd_metric` is a combinational read of the normalised metric of `rd_state`. During a step it shows the metrics from before the step, until the edge that raises `dec_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_start | input | 1 | Begins a trellis step; accompanies branch metric 0 |
| bm_in | input | 16 | Signed branch metric of the current butterfly |
| rd_state | input | 4 | State index for the metric read port |
| rd_metric | output | 16 | Normalised metric of `rd_state` (combinational) |
| pm_vld | output | 1 | New metrics of one butterfly are valid |
| pm_pair | output | 3 | Index of the butterfly whose result is shown |
| pm_even | output | 16 | New raw metric of state 2*pm_pair |
| pm_odd | output | 16 | New raw metric of state 2*pm_pair+1 |
| dec_done | output | 1 | One-cycle strobe marking the end of a step |
| dec_word | output | 16 | Packed decision bits of the finished step |

## Verification
The butterfly result for the branch metric driven in cycle t is due one cycle later. The decision word and its strobe are due one cycle after the eighth branch metric, and the metric read port answers within the same cycle. The bench drives every input on the falling edge. It checks the butterfly outputs and the done strobe on the next falling edge, one full register stage later, and it samples `rd_metric` a short delay after setting `rd_state`. It compares every value against a reference model of the trellis that is updated only at step boundaries.

// File: rtl/acs_pkg.sv
package acs_pkg;
   // True when n is a power of two and at least 4 (smallest usable trellis)
   function automatic bit trellis_size_ok(input int n);
      return (n >= 4) && ((n & (n - 1)) == 0);
   endfunction

   typedef enum logic {
      PICK_UPPER = 1'b0,
      PICK_LOWER = 1'b1
   } pick_e;
endpackage

// File: rtl/acs_select.sv
module acs_select #(
   parameter int MW = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic signed [MW-1:0] cand_up,
   input  logic signed [MW-1:0] cand_lo,
   output logic signed [MW-1:0] surv,
   output logic                 pick_lo
);
   import acs_pkg::*;

   pick_e pick;

   always_comb begin
      pick    = (cand_lo > cand_up) ? PICK_LOWER : PICK_UPPER;
      pick_lo = (pick == PICK_LOWER);
      surv    = pick_lo ? cand_lo : cand_up;
   end

   AST_SURVIVOR_MAX: assert property (@(posedge clk) disable iff (!rst_n)
      (surv >= cand_up) && (surv >= cand_lo)); // R3
   AST_TIE_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
      (cand_up == cand_lo) |-> !pick_lo); // R4
endmodule

// File: rtl/acs_seq.sv
module acs_seq #(
   parameter int NPAIR = 8,
   localparam int IW = $clog2(NPAIR)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   output logic          fire,
   output logic [IW-1:0] pair,
   output logic          last
);
   localparam logic [IW-1:0] LASTP = IW'(NPAIR - 1);

   logic          busy;
   logic [IW-1:0] cnt;

   assign fire = busy | start;
   assign pair = busy ? cnt : '0;
   assign last = fire && (pair == LASTP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         cnt  <= '0;
      end else if (fire) begin
         if (pair == LASTP) begin
            busy <= 1'b0;
            cnt  <= '0;
         end else begin
            busy <= 1'b1;
            cnt  <= pair + 1'b1;
         end
      end
   end

   AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cnt != LASTP) |=> (busy && cnt == $past(cnt) + 1'b1)); // R7
endmodule

// File: rtl/acs_metric_bank.sv
module acs_metric_bank #(
   parameter int MW      = 16,
   parameter int NSTATE  = 16,
   parameter bit NORM_EN = 1'b1,
   localparam int SW = $clog2(NSTATE),
   localparam int IW = SW - 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          swap,
   input  logic          we,
   input  logic [IW-1:0] wa_pair,
   input  logic [MW-1:0] wd_even,
   input  logic [MW-1:0] wd_odd,
   input  logic [SW-1:0] ra_a,
   input  logic [SW-1:0] ra_b,
   input  logic [SW-1:0] ra_c,
   output logic [MW-1:0] rd_a,
   output logic [MW-1:0] rd_b,
   output logic [MW-1:0] rd_c
);
   logic [MW-1:0] bank [2][NSTATE];
   logic          sel;
   logic [MW-1:0] base;

   generate
      if (NORM_EN) begin : g_norm
         assign base = bank[sel][0];
      end else begin : g_raw
         assign base = '0;
      end
   endgenerate

   assign rd_a = bank[sel][ra_a] - base;
   assign rd_b = bank[sel][ra_b] - base;
   assign rd_c = bank[sel][ra_c] - base;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel <= 1'b0;
         for (int b = 0; b < 2; b++)
            for (int s = 0; s < NSTATE; s++)
               bank[b][s] <= '0;
      end else begin
         if (we) begin
            bank[~sel][{wa_pair, 1'b0}] <= wd_even;
            bank[~sel][{wa_pair, 1'b1}] <= wd_odd;
         end
         if (swap) sel <= ~sel;
      end
   end

   AST_READ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(swap) && $stable(ra_c)) |-> $stable(rd_c)); // R9
endmodule

// File: rtl/acs_butterfly_core.sv
module acs_butterfly_core #(
   parameter int MW      = 16,
   parameter int NSTATE  = 16,
   parameter bit NORM_EN = 1'b1,
   localparam int SW    = $clog2(NSTATE),
   localparam int NPAIR = NSTATE / 2,
   localparam int IW    = SW - 1,
   localparam int DW    = NSTATE
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          step_start,
   input  logic [MW-1:0] bm_in,
   input  logic [SW-1:0] rd_state,
   output logic [MW-1:0] rd_metric,
   output logic          pm_vld,
   output logic [IW-1:0] pm_pair,
   output logic [MW-1:0] pm_even,
   output logic [MW-1:0] pm_odd,
   output logic          dec_done,
   output logic [DW-1:0] dec_word
);
   import acs_pkg::*;

   generate
      if (!trellis_size_ok(NSTATE)) begin : g_bad_size
         $error("NSTATE must be a power of two and at least 4");
      end
      if (MW < 4) begin : g_bad_width
         $error("MW must be at least 4");
      end
   endgenerate

   logic          fire, last;
   logic [IW-1:0] pair;
   logic [MW-1:0] old_a, old_b;
   logic [MW-1:0] surv [2];
   logic          dbit [2];
   logic [DW-1:0] dec_sr;
   logic [DW-1:0] dec_next;

   acs_seq #(.NPAIR(NPAIR)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(step_start),
      .fire(fire), .pair(pair), .last(last)
   );

   acs_metric_bank #(.MW(MW), .NSTATE(NSTATE), .NORM_EN(NORM_EN)) u_bank (
      .clk(clk), .rst_n(rst_n), .swap(last), .we(fire),
      .wa_pair(pair), .wd_even(surv[0]), .wd_odd(surv[1]),
      .ra_a({1'b0, pair}), .ra_b({1'b1, pair}), .ra_c(rd_state),
      .rd_a(old_a), .rd_b(old_b), .rd_c(rd_metric)
   );

   // g = 0 builds the even new state, g = 1 the odd one
   for (genvar g = 0; g < 2; g++) begin : g_cs
      logic signed [MW-1:0] c_up, c_lo;
      if (g == 0) begin : g_even
         assign c_up = old_a + bm_in;
         assign c_lo = old_b - bm_in;
      end else begin : g_odd
         assign c_up = old_a - bm_in;
         assign c_lo = old_b + bm_in;
      end
      acs_select #(.MW(MW)) u_sel (
         .clk(clk), .rst_n(rst_n), .cand_up(c_up), .cand_lo(c_lo),
         .surv(surv[g]), .pick_lo(dbit[g])
      );
   end

   assign dec_next = {dec_sr[DW-3:0], dbit[0], dbit[1]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pm_vld   <= 1'b0;
         pm_pair  <= '0;
         pm_even  <= '0;
         pm_odd   <= '0;
         dec_sr   <= '0;
         dec_done <= 1'b0;
         dec_word <= '0;
      end else begin
         pm_vld   <= fire;
         dec_done <= last;
         if (fire) begin
            pm_pair <= pair;
            pm_even <= surv[0];
            pm_odd  <= surv[1];
            dec_sr  <= dec_next;
         end
         if (last) dec_word <= dec_next;
      end
   end

   AST_PAIR_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      (pm_vld && pm_pair != IW'(NPAIR - 1)) |=> (pm_vld && pm_pair == $past(pm_pair) + 1'b1)); // R2
   AST_DONE_AT_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      (pm_vld && pm_pair == IW'(NPAIR - 1)) |-> dec_done); // R5
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      dec_done |=> !dec_done); // R5
endmodule

// File: tb/acs_butterfly_core_tb.sv
module acs_butterfly_core_tb;
   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic        rst_n, step_start, pm_vld, dec_done;
   logic [15:0] bm_in, rd_metric, pm_even, pm_odd, dec_word;
   logic [3:0]  rd_state;
   logic [2:0]  pm_pair;

   acs_butterfly_core u_dut (
      .clk(clk), .rst_n(rst_n), .step_start(step_start), .bm_in(bm_in),
      .rd_state(rd_state), .rd_metric(rd_metric), .pm_vld(pm_vld),
      .pm_pair(pm_pair), .pm_even(pm_even), .pm_odd(pm_odd),
      .dec_done(dec_done), .dec_word(dec_word)
   );

   int errs = 0;
   int checks = 0;

   logic signed [15:0] m   [16];
   logic signed [15:0] nxt [16];
   logic signed [15:0] exp_e [8];
   logic signed [15:0] exp_o [8];
   logic        [15:0] exp_dec;
   logic signed [15:0] bseq [32];

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic signed [15:0] smax(input logic signed [15:0] u, input logic signed [15:0] l);
      return (l > u) ? l : u;
   endfunction

   // Reference trellis step for butterflies at bseq[base .. base+7]
   task automatic model_step(input int base);
      logic signed [15:0] a, b, v, c0, c1, c2, c3;
      for (int j = 0; j < 8; j++) begin
         a = m[j]; b = m[j+8]; v = bseq[base+j];
         c0 = a + v; c1 = b - v; c2 = a - v; c3 = b + v;
         exp_e[j] = smax(c0, c1);
         exp_o[j] = smax(c2, c3);
         exp_dec[15-2*j] = (c1 > c0);      // R4: tie keeps upper, bit 0
         exp_dec[14-2*j] = (c3 > c2);
         nxt[2*j]   = exp_e[j];
         nxt[2*j+1] = exp_o[j];
      end
   endtask

   // n back-to-back steps; optional stray start in the middle of step 0
   task automatic run_steps(input int n, input bit poke);
      for (int t = 0; t <= 8*n; t++) begin
         @(negedge clk);
         if (t > 0) begin
            chk("R2 pm_vld", {15'd0, pm_vld}, 16'd1);
            chk("R2/R7 pm_pair", {13'd0, pm_pair}, 16'((t-1) % 8));
            chk("R3 even metric", pm_even, exp_e[(t-1) % 8]);
            chk("R3 odd metric", pm_odd, exp_o[(t-1) % 8]);
         end
         if (t > 0 && t % 8 == 0) begin
            chk("R5 done strobe", {15'd0, dec_done}, 16'd1);
            chk("R5 decision word", dec_word, exp_dec);
            for (int s = 0; s < 16; s++) m[s] = nxt[s] - nxt[0];  // R6
         end else if (t > 0) begin
            chk("R5 done low mid-step", {15'd0, dec_done}, 16'd0);
         end
         if (t < 8*n && t % 8 == 0) model_step(t);  // R8 uses fresh m
         if (t % 8 == 4) begin
            rd_state = 4'd5;
            #1 chk("R9 read holds old metric", rd_metric, m[5]);
         end
         step_start = (t < 8*n && t % 8 == 0) || (poke && t == 3);
         bm_in      = (t < 8*n) ? bseq[t] : 16'd0;
      end
      @(negedge clk);
      chk("R5 done single cycle", {15'd0, dec_done}, 16'd0);
      chk("R2 pm_vld idle", {15'd0, pm_vld}, 16'd0);
      for (int s = 0; s < 16; s++) begin
         rd_state = 4'(s);
         #1 chk("R6 normalised metric", rd_metric, m[s]);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errs++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      rst_n = 1'b0; step_start = 1'b0; bm_in = '0; rd_state = '0;
      for (int s = 0; s < 16; s++) m[s] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 pm_vld", {15'd0, pm_vld}, 16'd0);
      chk("R1 dec_done", {15'd0, dec_done}, 16'd0);
      for (int s = 0; s < 16; s++) begin
         rd_state = 4'(s);
         #1 chk("R1 metric zero", rd_metric, 16'd0);
      end

      // Directed: all-zero branch metrics -> ties everywhere (R4)
      for (int i = 0; i < 8; i++) bseq[i] = 16'sd0;
      run_steps(1, 1'b0);
      // Directed: uniform positive and negative metrics
      for (int i = 0; i < 8; i++) bseq[i] = 16'sd100;
      run_steps(1, 1'b0);
      for (int i = 0; i < 8; i++) bseq[i] = (i % 2 == 0) ? -16'sd300 : 16'sd7;
      run_steps(1, 1'b0);
      // Random back-to-back steps with a stray mid-step start (R7, R8)
      for (int r = 0; r < 6; r++) begin
         for (int i = 0; i < 32; i++) begin
            int v;
            v = int'($urandom_range(2000)) - 1000;
            bseq[i] = 16'(v);
         end
         run_steps(4, r[0]);
      end

      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule